// File: doc/BRIEF.md
# Three-Button Step Counter

This block keeps a 6-bit count that three push-button levels change: one button lowers the count by one, one raises it by four, and one clears it. A single system clock runs all of the logic. Each button level goes into its own short history register on every clock edge. A press is recognised from that history, and the press then acts as a one-cycle enable on the count register. No button is ever used as a clock. Only one process writes the count, so two buttons can never drive it against each other.

The history register also removes contact bounce. An action starts only when the button has read low and then high on two samples in a row. A button that is held down gives one action and no repeats. A glitch that lasts one sample gives no action. When presses on more than one button are seen in the same cycle, a fixed priority chooses the one that acts.

Top module: `stepcnt_top`

## Requirements
- R1: The count is 6 bits wide and holds zero from power-up until the first recognised press.
- R2: Each button has its own 3-bit history register that shifts on every rising clock edge, with the newest sample entering bit 0 and older samples moving toward bit 2.
- R3: A press is recognised only when a history holds 011, that is bit 2 = 0 and bits 1 and 0 = 1. A button held high for any number of cycles gives exactly one action.
- R4: A high level lasting a single sample, or an alternating level that gives histories such as 010 or 101, causes no change to the count.
- R5: A recognised up press adds 4 to the count modulo 64, so 60 becomes 0 and 63 becomes 3.
- R6: A recognised down press subtracts 1 from the count modulo 64, so 0 becomes 63.
- R7: A recognised reset press sets the count to 0.
- R8: When presses are recognised on several buttons in the same cycle, reset wins over up and up wins over down. Only the winning action is applied.
- R9: The count changes on the clock edge right after the edge that completes the 011 history. For a button that goes high before edge n and stays high, the new value is visible after edge n+2 and not before.
- R10: In a cycle with no recognised press, the count keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all registers update on its rising edge |
| btn_dn | input | 1 | Raw level of the button that steps the count down by 1 |
| btn_up | input | 1 | Raw level of the button that steps the count up by 4 |
| btn_rst | input | 1 | Raw level of the button that clears the count |
| count | output | 6 | Current count value |

## Verification
Clean presses of two highs followed by lows drive the count through both wrap points. These tell a step of four apart from other steps, and a modulo wrap apart from saturation. A button held for many cycles shows whether an action repeats. One-sample glitches and the 1,0,1,1 level sequence show whether the detector keys on the exact 011 history and on the shift direction. Presses that land on the same cycle, reset with up and down or up with down, show the priority order. A cycle-exact model compared after every edge pins the single cycle of latency between detection and update.

// File: rtl/stepcnt_pkg.sv
package stepcnt_pkg;

  // Index of each button inside the packed button vectors.
  localparam int BTN_DN  = 0;
  localparam int BTN_UP  = 1;
  localparam int BTN_RST = 2;
  localparam int NUM_BTN = 3;

  // Action chosen for the count register in one cycle.
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_DEC  = 2'd1,
    ACT_INC  = 2'd2,
    ACT_CLR  = 2'd3
  } act_e;

endpackage

// File: rtl/stepcnt_press_detect.sv
module stepcnt_press_detect #(
  parameter int HIST_W = 3
) (
  input  logic clk,
  input  logic raw,
  output logic hit
);

  // A press is a low sample followed by HIST_W-1 high samples (011 for a width of 3).
  localparam logic [HIST_W-1:0] PRESS_PAT = {1'b0, {(HIST_W-1){1'b1}}};

  logic [HIST_W-1:0] hist_q = '0;
  logic [1:0]        age_q  = '0;
  logic              armed;

  // Newest sample enters bit 0.
  always_ff @(posedge clk) begin
    hist_q <= {hist_q[HIST_W-2:0], raw};
  end

  // This counter only says how far $past may look back. It does not change behaviour.
  always_ff @(posedge clk) begin
    if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  assign armed = (age_q == 2'd3);

  assign hit = (hist_q == PRESS_PAT);

  // R3: a held button gives one pulse only.
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!armed)
    hit |=> !hit);

  // R2 and R4: a hit needs the two latest samples high and the one before them low.
  assert_two_highs_R4: assert property (@(posedge clk) disable iff (!armed)
    hit |-> ($past(raw) && $past(raw, 2) && !$past(raw, 3)));

endmodule

// File: rtl/stepcnt_arbiter.sv
module stepcnt_arbiter
  import stepcnt_pkg::*;
(
  input  logic [NUM_BTN-1:0] hits,
  output act_e               act
);

  // Fixed priority: reset, then up, then down.
  always_comb begin
    if (hits[BTN_RST])     act = ACT_CLR;
    else if (hits[BTN_UP]) act = ACT_INC;
    else if (hits[BTN_DN]) act = ACT_DEC;
    else                   act = ACT_NONE;
  end

endmodule

// File: rtl/stepcnt_count_reg.sv
module stepcnt_count_reg
  import stepcnt_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int UP_STEP = 4,
  parameter int DN_STEP = 1
) (
  input  logic             clk,
  input  act_e             act,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] UP_INC = CNT_W'(UP_STEP);
  localparam logic [CNT_W-1:0] DN_DEC = CNT_W'(DN_STEP);

  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] v);
    return v + UP_INC;
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - DN_DEC;
  endfunction

  logic [CNT_W-1:0] count_q = '0;
  logic             armed_q = 1'b0;

  // This is the only process that writes the count.
  always_ff @(posedge clk) begin
    unique case (act)
      ACT_CLR:  count_q <= '0;
      ACT_INC:  count_q <= step_up(count_q);
      ACT_DEC:  count_q <= step_down(count_q);
      default:  count_q <= count_q;
    endcase
  end

  always_ff @(posedge clk) armed_q <= 1'b1;

  assign count = count_q;

  assert_clear_R7: assert property (@(posedge clk) disable iff (!armed_q)
    (act == ACT_CLR) |=> (count_q == '0));

  assert_up_wrap_R5: assert property (@(posedge clk) disable iff (!armed_q)
    (act == ACT_INC) |=> (int'(count_q) == ((int'($past(count_q)) + UP_STEP) % (1 << CNT_W))));

  assert_down_wrap_R6: assert property (@(posedge clk) disable iff (!armed_q)
    (act == ACT_DEC) |=>
      (int'(count_q) == ((int'($past(count_q)) + (1 << CNT_W) - DN_STEP) % (1 << CNT_W))));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!armed_q)
    (act == ACT_NONE) |=> $stable(count_q));

endmodule

// File: rtl/stepcnt_top.sv
module stepcnt_top
  import stepcnt_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int HIST_W  = 3,
  parameter int UP_STEP = 4,
  parameter int DN_STEP = 1
) (
  input  logic             clk,
  input  logic             btn_dn,
  input  logic             btn_up,
  input  logic             btn_rst,
  output logic [CNT_W-1:0] count
);

  logic [NUM_BTN-1:0] btn_raw;
  logic [NUM_BTN-1:0] hits;
  act_e               act;
  logic               armed_q = 1'b0;

  always_comb begin
    btn_raw          = '0;
    btn_raw[BTN_DN]  = btn_dn;
    btn_raw[BTN_UP]  = btn_up;
    btn_raw[BTN_RST] = btn_rst;
  end

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_det
    stepcnt_press_detect #(.HIST_W(HIST_W)) u_det (
      .clk (clk),
      .raw (btn_raw[b]),
      .hit (hits[b])
    );
  end

  stepcnt_arbiter u_arb (
    .hits (hits),
    .act  (act)
  );

  stepcnt_count_reg #(
    .CNT_W   (CNT_W),
    .UP_STEP (UP_STEP),
    .DN_STEP (DN_STEP)
  ) u_cnt (
    .clk   (clk),
    .act   (act),
    .count (count)
  );

  always_ff @(posedge clk) armed_q <= 1'b1;

  // R1: the count starts at zero before any clock edge.
  initial assert_start_zero_R1: assert (count == '0);

  // R8: a reset hit clears the count whatever the other buttons do.
  assert_rst_wins_R8: assert property (@(posedge clk) disable iff (!armed_q)
    hits[BTN_RST] |=> (count == '0));

  // R8: when up and down hit together, the count moves up.
  assert_up_over_dn_R8: assert property (@(posedge clk) disable iff (!armed_q)
    (hits[BTN_UP] && hits[BTN_DN] && !hits[BTN_RST]) |=>
      (int'(count) == ((int'($past(count)) + UP_STEP) % (1 << CNT_W))));

  // R9: the count can change only one edge after a hit.
  assert_change_after_hit_R9: assert property (@(posedge clk) disable iff (!armed_q)
    (count != $past(count)) |-> $past(hits != '0));

endmodule

// File: tb/sim_stepcnt_top.sv
module sim_stepcnt_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       b_dn = 1'b0;
  logic       b_up = 1'b0;
  logic       b_rs = 1'b0;
  logic [5:0] count;

  always #(CLK_PERIOD/2) clk = ~clk;

  stepcnt_top u0 (
    .clk     (clk),
    .btn_dn  (b_dn),
    .btn_up  (b_up),
    .btn_rst (b_rs),
    .count   (count)
  );

  int vectors     = 0;
  int miscompares = 0;
  bit finished    = 1'b0;

  // Behavioural reference: one history per button (0 down, 1 up, 2 reset) and a count.
  int hist [3] = '{0, 0, 0};
  int mcount   = 0;

  task automatic check(input int actual, input int expected, input string tag);
    vectors++;
    if (actual != expected) begin
      miscompares++;
      $display("FAIL %s: count=%0d expected %0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // Drive the levels, advance one edge, update the model, compare at the falling edge.
  task automatic step(input bit d, input bit u, input bit r, input string tag);
    bit det [3];
    int lv  [3];
    b_dn = d; b_up = u; b_rs = r;
    lv[0] = int'(d); lv[1] = int'(u); lv[2] = int'(r);
    @(posedge clk);
    for (int b = 0; b < 3; b++) det[b] = ((hist[b] & 7) == 3);
    if (det[2])      mcount = 0;
    else if (det[1]) mcount = (mcount + 4) % 64;
    else if (det[0]) mcount = (mcount + 63) % 64;
    for (int b = 0; b < 3; b++) hist[b] = ((hist[b] << 1) | lv[b]) & 7;
    #(CLK_PERIOD/2);
    check(int'(count), mcount, tag);
  endtask

  task automatic hold(input bit d, input bit u, input bit r, input int n, input string tag);
    for (int i = 0; i < n; i++) step(d, u, r, tag);
  endtask

  // A clean press: two high samples, then two low samples.
  task automatic press(input bit d, input bit u, input bit r, input string tag);
    hold(d, u, r, 2, tag);
    hold(1'b0, 1'b0, 1'b0, 2, tag);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #1;
    check(int'(count), 0, "R1 power-up value");
    hold(0, 0, 0, 3, "R10 idle");

    // R9: the down level is high before three edges; the count moves only after the third.
    step(1, 0, 0, "R9 edge 1");
    check(int'(count), 0, "R9 unchanged after edge 1");
    step(1, 0, 0, "R9 edge 2");
    check(int'(count), 0, "R9 unchanged after edge 2");
    step(1, 0, 0, "R9 edge 3");
    check(int'(count), 63, "R6 down wraps 0 to 63");
    hold(1, 0, 0, 6, "R3 held down");
    check(int'(count), 63, "R3 held button acts once");
    hold(0, 0, 0, 3, "R10 idle");

    // R4: one-sample glitches on up and on reset.
    for (int i = 0; i < 4; i++) begin
      step(0, 1, 0, "R4 up glitch");
      step(0, 0, 1, "R4 rst glitch");
    end
    hold(0, 0, 0, 3, "R4 settle");
    check(int'(count), 63, "R4 bounce ignored");

    // R2: levels 1,0,1,1 give histories 001,010,101,011, so exactly one press.
    step(0, 1, 0, "R2 seq");
    step(0, 0, 0, "R2 seq");
    step(0, 1, 0, "R2 seq");
    step(0, 1, 0, "R2 seq");
    hold(0, 0, 0, 2, "R2 seq");
    check(int'(count), 3, "R2 one press from 1,0,1,1");

    // R5: sixteen up presses from 3 wrap all the way back to 3.
    for (int i = 0; i < 16; i++) press(0, 1, 0, "R5 up steps");
    check(int'(count), 3, "R5 up wrap");

    press(0, 0, 1, "R7 reset");
    check(int'(count), 0, "R7 reset clears");

    // R8: simultaneous presses.
    press(0, 1, 0, "R8 setup");
    press(1, 1, 1, "R8 all three");
    check(int'(count), 0, "R8 reset wins");
    press(1, 1, 0, "R8 up and down");
    check(int'(count), 4, "R8 up over down");
    press(1, 0, 1, "R8 down and reset");
    check(int'(count), 0, "R8 reset over down");
    press(1, 0, 0, "R6 down");
    check(int'(count), 63, "R6 down wrap again");
    hold(0, 0, 0, 4, "R10 final idle");
    check(int'(count), 63, "R10 value held");

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL R9 watchdog: run actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule